// File: doc/BRIEF.md
# Streaming Binary Component Labeller

This block takes a thresholded binary image as a raster stream. Lines arrive top first, and pixels within a line arrive left to right. It gives every set pixel a non-zero label. The label depends only on the label of the pixel to its left and the label of the pixel directly above it. The label above is read from a single line of label storage. Pixels join only through horizontal or vertical contact. When both neighbours carry different labels, the row neighbour wins and the block reports the pair of labels as an equivalence. The downstream logic that merges regions and gathers features uses these reports. Each freshly allocated label is also announced as an event.

There is only one line of storage. Equivalence reports alone would not let two branches that meet further down be joined. To handle this, the block rewrites the stored line as it goes. After a vertical link merges a subordinate label into the row label, later stored entries that carry the subordinate label are read as the row label for the rest of that line. Labels are handed out in ascending order from 1 and start again at 1 on each start of frame. When the pool runs out, the block raises a sticky overflow flag.

Top module: `cc_stream_labeller`

## Requirements
- R1: A cleared pixel gets label 0 and raises no event. A pixel at column LINE_W or beyond also gets label 0 and raises no event. The column counts from 0 at a start-of-frame beat and again after an end-of-line beat.
- R2: A set pixel whose left neighbour has a non-zero label takes that label, whatever the pixel above holds.
- R3: A set pixel whose left label is 0 and whose upper label is non-zero takes the upper label.
- R4: A set pixel with both neighbour labels 0 takes the next free label. Labels are given in ascending order starting from 1. In the same output cycle, new_valid is high and new_label equals out_label.
- R5: A set pixel whose left and upper labels are both non-zero and different takes the left label. It raises conf_valid with conf_dom set to the left label and conf_sub set to the upper label.
- R6: A set pixel whose only set neighbour is diagonal (above-left or above-right) starts a new label.
- R7: After an R5 conflict, stored upper labels equal to conf_sub are read as conf_dom for the rest of that line.
- R8: A start-of-frame beat treats its whole first line as having zero labels above it, and restarts label allocation at 1.
- R9: When a fresh label is needed and all NUM_LABELS labels are used, the pixel gets label 0 and no new-label event is raised. The overflow output then rises and stays high until reset.
- R10: in_ready is high whenever the block is out of reset. Each accepted beat gives exactly one output beat on out_valid in the following cycle. Output beats come out in input order, and no output beat appears without an accepted beat.
- R11: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel beat valid |
| in_ready | output | 1 | Block accepts a beat |
| in_pix | input | 1 | Binary pixel value |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_eol | input | 1 | Beat is the last pixel of a line |
| out_valid | output | 1 | Output beat valid |
| out_label | output | LW | Label of the pixel, 0 for background |
| conf_valid | output | 1 | Equivalence pair reported |
| conf_dom | output | LW | Dominant (left) label of the pair |
| conf_sub | output | LW | Subordinate (upper) label of the pair |
| new_valid | output | 1 | A fresh label was allocated |
| new_label | output | LW | The freshly allocated label |
| overflow | output | 1 | Sticky flag: label pool exhausted |

## Verification
The bench builds the block with a line of 6 pixels and a pool of only 4 labels. With a pool that small, a few short lines exhaust it, so the overflow path and its sticky flag are reached within a second frame. The narrow line makes it cheap to feed a beat past the last column and to follow a stored-line rewrite across a single line. Two back-to-back frames show that the first line ignores the storage left over from the earlier frame and that allocation restarts at 1.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        PAINT_NONE,
        PAINT_LEFT,
        PAINT_UP,
        PAINT_NEW
    } paint_e;

    function automatic paint_e classify(input logic pix, input logic left_nz, input logic up_nz);
        if (!pix)         return PAINT_NONE;
        else if (left_nz) return PAINT_LEFT;
        else if (up_nz)   return PAINT_UP;
        else              return PAINT_NEW;
    endfunction

endpackage

// File: rtl/cc_line_mem.sv
module cc_line_mem #(
    parameter int LINE_W = 600,
    parameter int LW     = 7,
    localparam int AW    = $clog2(LINE_W)
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [LW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [LW-1:0] wr_data
);
    logic [LW-1:0] cells_q [LINE_W];

    assign rd_data = cells_q[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) cells_q[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/cc_label_pool.sv
module cc_label_pool #(
    parameter int NUM_LABELS = 100,
    parameter int LW         = 7,
    localparam int CNTW      = $clog2(NUM_LABELS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          take,
    output logic [LW-1:0] grant,
    output logic          empty
);
    localparam logic [CNTW-1:0] LIMIT = CNTW'(NUM_LABELS);

    logic [CNTW-1:0] next_q, next_d, base;

    always_comb begin
        base   = restart ? CNTW'(1) : next_q;
        empty  = base > LIMIT;
        grant  = LW'(base);
        next_d = (take && !empty) ? base + CNTW'(1) : base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) next_q <= CNTW'(1);
        else        next_q <= next_d;
    end

    assert_pool_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        next_q <= LIMIT + CNTW'(1));
endmodule

// File: rtl/cc_paint.sv
module cc_paint
    import cc_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic          pix,
    input  logic [LW-1:0] left_lab,
    input  logic [LW-1:0] up_raw,
    input  logic          rep_valid,
    input  logic [LW-1:0] rep_from,
    input  logic [LW-1:0] rep_to,
    input  logic [LW-1:0] grant,
    input  logic          pool_empty,
    output logic [LW-1:0] lab,
    output logic [LW-1:0] up_eff,
    output logic          conflict,
    output logic          take,
    output logic          ovf_hit
);
    paint_e kind;

    always_comb begin
        up_eff   = (rep_valid && up_raw == rep_from && up_raw != '0) ? rep_to : up_raw;
        kind     = classify(pix, left_lab != '0, up_eff != '0);
        lab      = '0;
        take     = 1'b0;
        ovf_hit  = 1'b0;
        conflict = 1'b0;
        unique case (kind)
            PAINT_NONE: lab = '0;
            PAINT_LEFT: begin
                lab      = left_lab;
                conflict = (up_eff != '0) && (up_eff != left_lab);
            end
            PAINT_UP:   lab = up_eff;
            PAINT_NEW: begin
                take    = 1'b1;
                ovf_hit = pool_empty;
                lab     = pool_empty ? '0 : grant;
            end
        endcase
    end
endmodule

// File: rtl/cc_stream_labeller.sv
module cc_stream_labeller #(
    parameter int LINE_W     = 600,
    parameter int NUM_LABELS = 100,
    localparam int LW        = $clog2(NUM_LABELS + 1),
    localparam int AW        = $clog2(LINE_W),
    localparam int CW        = $clog2(LINE_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_pix,
    input  logic          in_sof,
    input  logic          in_eol,
    output logic          out_valid,
    output logic [LW-1:0] out_label,
    output logic          conf_valid,
    output logic [LW-1:0] conf_dom,
    output logic [LW-1:0] conf_sub,
    output logic          new_valid,
    output logic [LW-1:0] new_label,
    output logic          overflow
);
    localparam logic [CW-1:0] LAST = CW'(LINE_W);

    typedef struct packed {
        logic [CW-1:0] col;
        logic          row0;
        logic [LW-1:0] left;
        logic          rep_v;
        logic [LW-1:0] rep_from;
        logic [LW-1:0] rep_to;
        logic          rdy;
        logic          ovf;
        logic          o_valid;
        logic [LW-1:0] o_label;
        logic          c_valid;
        logic [LW-1:0] c_dom;
        logic [LW-1:0] c_sub;
        logic          n_valid;
        logic [LW-1:0] n_label;
    } state_t;

    state_t s_q, s_d;

    logic          acc, in_frame, row0_now, rep_now;
    logic [CW-1:0] col_now;
    logic [LW-1:0] left_now, mem_rd, up_raw;
    logic [LW-1:0] lab, up_eff, grant;
    logic          conflict, take, ovf_hit, pool_empty;
    logic [AW-1:0] addr;

    always_comb begin
        acc      = in_valid && s_q.rdy;
        col_now  = in_sof ? '0 : s_q.col;
        row0_now = in_sof | s_q.row0;
        left_now = in_sof ? '0 : s_q.left;
        rep_now  = in_sof ? 1'b0 : s_q.rep_v;
        in_frame = col_now < LAST;
        addr     = in_frame ? col_now[AW-1:0] : '0;
        up_raw   = (row0_now || !in_frame) ? '0 : mem_rd;
    end

    cc_line_mem #(.LINE_W(LINE_W), .LW(LW)) u_mem (
        .clk     (clk),
        .rd_addr (addr),
        .rd_data (mem_rd),
        .wr_en   (acc && in_frame),
        .wr_addr (addr),
        .wr_data (lab)
    );

    cc_label_pool #(.NUM_LABELS(NUM_LABELS), .LW(LW)) u_pool (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (acc && in_sof),
        .take    (acc && take),
        .grant   (grant),
        .empty   (pool_empty)
    );

    cc_paint #(.LW(LW)) u_paint (
        .pix        (in_pix && in_frame),
        .left_lab   (left_now),
        .up_raw     (up_raw),
        .rep_valid  (rep_now),
        .rep_from   (s_q.rep_from),
        .rep_to     (s_q.rep_to),
        .grant      (grant),
        .pool_empty (pool_empty),
        .lab        (lab),
        .up_eff     (up_eff),
        .conflict   (conflict),
        .take       (take),
        .ovf_hit    (ovf_hit)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rdy     = 1'b1;
        s_d.o_valid = acc;
        s_d.c_valid = 1'b0;
        s_d.n_valid = 1'b0;
        if (acc) begin
            s_d.o_label = lab;
            s_d.c_valid = conflict;
            s_d.c_dom   = conflict ? lab : '0;
            s_d.c_sub   = conflict ? up_eff : '0;
            s_d.n_valid = take && !pool_empty;
            s_d.n_label = (take && !pool_empty) ? lab : '0;
            s_d.ovf     = s_q.ovf | ovf_hit;
            if (in_eol) begin
                s_d.col   = '0;
                s_d.row0  = 1'b0;
                s_d.left  = '0;
                s_d.rep_v = 1'b0;
            end else begin
                s_d.col   = (col_now == LAST) ? LAST : col_now + CW'(1);
                s_d.row0  = row0_now;
                s_d.left  = lab;
                s_d.rep_v = rep_now | conflict;
                if (conflict) begin
                    s_d.rep_from = up_eff;
                    s_d.rep_to   = lab;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready   = s_q.rdy;
    assign out_valid  = s_q.o_valid;
    assign out_label  = s_q.o_label;
    assign conf_valid = s_q.c_valid;
    assign conf_dom   = s_q.c_dom;
    assign conf_sub   = s_q.c_sub;
    assign new_valid  = s_q.n_valid;
    assign new_label  = s_q.n_label;
    assign overflow   = s_q.ovf;

    assert_conf_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conf_valid |-> (conf_dom != '0 && conf_sub != '0 && conf_dom != conf_sub
                        && out_label == conf_dom && out_valid));
    assert_new_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        new_valid |-> (out_valid && out_label == new_label && new_label != '0));
    assert_no_overflow_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_overflow_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (out_valid && out_label == '0 && !new_valid));
    assert_one_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready));
endmodule

// File: tb/cc_stream_labeller_test.sv
module cc_stream_labeller_test;
    localparam int LW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_pix = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic in_ready, out_valid, conf_valid, new_valid, overflow;
    logic [LW-1:0] out_label, conf_dom, conf_sub, new_label;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    cc_stream_labeller #(.LINE_W(6), .NUM_LABELS(4)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_label(out_label),
        .conf_valid(conf_valid), .conf_dom(conf_dom), .conf_sub(conf_sub),
        .new_valid(new_valid), .new_label(new_label), .overflow(overflow)
    );

    typedef struct packed {
        logic       sof, eol, pix;
        logic [2:0] lab;
        logic       nw, cv;
        logic [2:0] dom, sub;
        logic       ov;
        logic [3:0] req;
    } vec_t;

    function automatic vec_t mk(input bit sof, eol, pix, input int lab, input bit nw, cv,
                                input int dom, sub, input bit ov, input int req);
        vec_t v;
        v.sof = sof; v.eol = eol; v.pix = pix; v.lab = lab[2:0];
        v.nw = nw; v.cv = cv; v.dom = dom[2:0]; v.sub = sub[2:0];
        v.ov = ov; v.req = req[3:0];
        return v;
    endfunction

    function automatic string tag(input logic [3:0] code);
        case (code)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            4'd10: return "R10"; default: return "R11";
        endcase
    endfunction

    localparam int NV = 43;
    localparam vec_t VEC [NV] = '{
        // frame A, line 0: 1 1 0 1 0 1
        mk(1,0,1,1,1,0,0,0,0,4), mk(0,0,1,1,0,0,0,0,0,2), mk(0,0,0,0,0,0,0,0,0,1),
        mk(0,0,1,2,1,0,0,0,0,4), mk(0,0,0,0,0,0,0,0,0,1), mk(0,1,1,3,1,0,0,0,0,4),
        // line 1: 0 1 1 1 1 1 + beat past the last column (R1)
        mk(0,0,0,0,0,0,0,0,0,1), mk(0,0,1,1,0,0,0,0,0,3), mk(0,0,1,1,0,0,0,0,0,2),
        mk(0,0,1,1,0,1,1,2,0,5), mk(0,0,1,1,0,0,0,0,0,2), mk(0,0,1,1,0,1,1,3,0,5),
        mk(0,1,1,0,0,0,0,0,0,1),
        // line 2: 1 0 1 0 0 0, column 0 touches only diagonally (R6)
        mk(0,0,1,4,1,0,0,0,0,6), mk(0,0,0,0,0,0,0,0,0,1), mk(0,0,1,1,0,0,0,0,0,3),
        mk(0,0,0,0,0,0,0,0,0,1), mk(0,0,0,0,0,0,0,0,0,1), mk(0,1,0,0,0,0,0,0,0,1),
        // frame B, line 0: 1 0 1 1 1 0, stale storage ignored (R8)
        mk(1,0,1,1,1,0,0,0,0,8), mk(0,0,0,0,0,0,0,0,0,1), mk(0,0,1,2,1,0,0,0,0,4),
        mk(0,0,1,2,0,0,0,0,0,2), mk(0,0,1,2,0,0,0,0,0,2), mk(0,1,0,0,0,0,0,0,0,1),
        // line 1: 1 1 1 0 1 0, column 4 reads rewritten label (R7)
        mk(0,0,1,1,0,0,0,0,0,3), mk(0,0,1,1,0,0,0,0,0,2), mk(0,0,1,1,0,1,1,2,0,5),
        mk(0,0,0,0,0,0,0,0,0,1), mk(0,0,1,1,0,0,0,0,0,7), mk(0,1,0,0,0,0,0,0,0,1),
        // line 2: 0 1 0 1 0 1
        mk(0,0,0,0,0,0,0,0,0,1), mk(0,0,1,1,0,0,0,0,0,3), mk(0,0,0,0,0,0,0,0,0,1),
        mk(0,0,1,3,1,0,0,0,0,4), mk(0,0,0,0,0,0,0,0,0,1), mk(0,1,1,4,1,0,0,0,0,4),
        // line 3: 1 0 1 0 0 0, pool exhausted (R9)
        mk(0,0,1,0,0,0,0,0,1,9), mk(0,0,0,0,0,0,0,0,1,9), mk(0,0,1,0,0,0,0,0,1,9),
        mk(0,0,0,0,0,0,0,0,1,1), mk(0,0,0,0,0,0,0,0,1,1), mk(0,1,0,0,0,0,0,0,1,1)
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R10 watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs held at zero in reset
        check("R11", "in_ready", int'(in_ready), 0);
        check("R11", "out_valid", int'(out_valid), 0);
        check("R11", "overflow", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "in_ready", int'(in_ready), 1);
        check("R10", "idle out_valid", int'(out_valid), 0);

        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_sof   = VEC[i].sof;
            in_eol   = VEC[i].eol;
            in_pix   = VEC[i].pix;
            @(negedge clk);
            check(tag(VEC[i].req), $sformatf("vec %0d out_valid", i), int'(out_valid), 1);
            check(tag(VEC[i].req), $sformatf("vec %0d label", i), int'(out_label), int'(VEC[i].lab));
            check(tag(VEC[i].req), $sformatf("vec %0d new_valid", i), int'(new_valid), int'(VEC[i].nw));
            if (VEC[i].nw)
                check(tag(VEC[i].req), $sformatf("vec %0d new_label", i), int'(new_label), int'(VEC[i].lab));
            check(tag(VEC[i].req), $sformatf("vec %0d conf_valid", i), int'(conf_valid), int'(VEC[i].cv));
            if (VEC[i].cv) begin
                check(tag(VEC[i].req), $sformatf("vec %0d conf_dom", i), int'(conf_dom), int'(VEC[i].dom));
                check(tag(VEC[i].req), $sformatf("vec %0d conf_sub", i), int'(conf_sub), int'(VEC[i].sub));
            end
            check(tag(VEC[i].req), $sformatf("vec %0d overflow", i), int'(overflow), int'(VEC[i].ov));
            if (i % 5 == 4) begin
                in_valid = 1'b0;
                in_pix   = 1'b1;
                @(negedge clk);
                // R10: no output beat without an accepted beat
                check("R10", $sformatf("gap after vec %0d", i), int'(out_valid), 0);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R10", "drained out_valid", int'(out_valid), 0);
        check("R9", "overflow held", int'(overflow), 1);

        rst_n = 1'b0;
        @(negedge clk);
        // R11: reset clears the sticky flag and the outputs
        check("R11", "overflow in reset", int'(overflow), 0);
        check("R11", "label in reset", int'(out_label), 0);
        check("R11", "in_ready in reset", int'(in_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eol = 1'b0; in_pix = 1'b1;
        @(negedge clk);
        check("R4", "first label after reset", int'(out_label), 1);
        in_valid = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule